// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block sits on the sending side of a buffered point-to-point link. Before each flit is launched, the block decides whether the receiver can take it. The sender raises `send_req` whenever it has a flit ready. The flit actually goes out in a cycle where both `send_req` and `send_ok` are high.

In counted-credit mode, the block keeps a tally of free flit slots in the receiver. Every flit that goes out uses one slot. The receiver sends back a one-cycle `credit_ret` pulse each time it drains a slot, and each pulse adds one slot back. To keep the link at full rate, the receiver must hold at least as many slots as the credit round trip takes in cycles.

In on/off mode, the tally is not used. The receiver drives a single `link_off` level when its free space drops to a margin that covers the flits still in flight. The sender stops for as long as that level is high. This mode needs one wire instead of a stream of credit pulses, but it leaves the margin unused. The mode is a build-time parameter.

Top module: `link_credit_ctrl`

## Requirements
- R1: In counted-credit mode, `credit_cnt` equals `BUF_DEPTH` (default 4) in the first cycle after reset, including after a reset applied in the middle of operation.
- R2: In counted-credit mode, `send_ok` is high exactly when `credit_cnt` is nonzero, in the same cycle, whether or not `send_req` is high.
- R3: In counted-credit mode, a cycle with `send_req` and `send_ok` high and no `credit_ret` lowers `credit_cnt` by one at the next clock edge.
- R4: In counted-credit mode, a `credit_ret` pulse with no flit sent and `credit_cnt` below `BUF_DEPTH` raises `credit_cnt` by one at the next clock edge.
- R5: In counted-credit mode, a flit sent in the same cycle as a credit return, with `credit_cnt` below `BUF_DEPTH`, leaves `credit_cnt` unchanged.
- R6: `credit_cnt` never exceeds `BUF_DEPTH`. A `credit_ret` arriving while the count equals `BUF_DEPTH` is dropped, even if a flit is sent in that cycle, so the count then falls by one.
- R7: In counted-credit mode, `send_req` while `credit_cnt` is zero sends nothing, and the count stays at zero.
- R8: In on/off mode, `send_ok` is the inverse of `link_off` in the same cycle. `credit_cnt` reads zero, and `credit_ret` has no effect on it.
- R9: In counted-credit mode, `link_off` has no effect on either `send_ok` or `credit_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Sender has a flit ready |
| credit_ret | input | 1 | One-cycle pulse: the receiver freed one slot |
| link_off | input | 1 | Receiver asks the sender to pause (on/off mode) |
| send_ok | output | 1 | A flit may be launched this cycle |
| credit_cnt | output | $clog2(BUF_DEPTH+1) | Free receiver slots known to the sender |

## Verification
Two corner cases are hard to reach from the ports:
- **Credit arriving while the tally is already full.** The stimulus first drains all credits with back-to-back sends. It then returns them one by one until the count is back at the depth. Finally it pushes one extra pulse alone, and another pulse together with a send, to show the extra credit is dropped.
- **Flit sent in the same cycle a credit returns.** This case is placed right after the tally has been emptied and refilled by one credit, so a send and a return coincide at a low count.

A second instance built in on/off mode receives the same inputs, which confirms that credit pulses leave its zero reading untouched.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Flow-control policy selected at build time
    typedef enum logic {
        FC_CREDIT = 1'b0,
        FC_ONOFF  = 1'b1
    } fc_mode_e;

    // Per-cycle events that move the credit tally
    typedef struct packed {
        logic take;   // a flit leaves, one slot consumed
        logic give;   // a slot comes back
    } fc_evt_t;

    // Width needed to hold values 0..depth
    function automatic int fc_cnt_w(input int depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fc_credit_ctr.sv
module fc_credit_ctr
    import fc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = fc_cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req,
    input  logic          ret,
    output logic [CW-1:0] cnt,
    output logic          ok
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    fc_evt_t       ev;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        ok      = (cnt != '0);
        ev.take = en & req & ok;
        ev.give = en & ret & (cnt != FULL);
        unique case ({ev.take, ev.give})
            2'b10:   cnt_nx = cnt - 1'b1;
            2'b01:   cnt_nx = cnt + 1'b1;
            default: cnt_nx = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= FULL;
        else     cnt <= cnt_nx;
    end

endmodule

// File: rtl/fc_onoff_gate.sv
module fc_onoff_gate (
    input  logic link_off,
    output logic ok
);

    // The receiver's threshold already covers flits in flight, so the
    // pause level can gate the sender without a register stage.
    always_comb ok = ~link_off;

endmodule

// File: rtl/link_credit_ctrl.sv
module link_credit_ctrl
    import fc_pkg::*;
#(
    parameter int       BUF_DEPTH = 4,
    parameter fc_mode_e MODE      = FC_CREDIT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             send_req,
    input  logic                             credit_ret,
    input  logic                             link_off,
    output logic                             send_ok,
    output logic [fc_cnt_w(BUF_DEPTH)-1:0]   credit_cnt
);

    localparam int   CW    = fc_cnt_w(BUF_DEPTH);
    localparam logic IS_CR = (MODE == FC_CREDIT);

    logic          cr_ok;
    logic [CW-1:0] cr_cnt;
    logic          oo_ok;

    fc_credit_ctr #(
        .DEPTH (BUF_DEPTH),
        .CW    (CW)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .en  (IS_CR),
        .req (send_req),
        .ret (credit_ret),
        .cnt (cr_cnt),
        .ok  (cr_ok)
    );

    fc_onoff_gate u_gate (
        .link_off (link_off),
        .ok       (oo_ok)
    );

    always_comb begin
        send_ok    = IS_CR ? cr_ok  : oo_ok;
        credit_cnt = IS_CR ? cr_cnt : '0;
    end

endmodule

// File: rtl/link_credit_ctrl_chk.sv
module link_credit_ctrl_chk
    import fc_pkg::*;
#(
    parameter int       BUF_DEPTH = 4,
    parameter fc_mode_e MODE      = FC_CREDIT
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           send_req,
    input logic                           credit_ret,
    input logic                           link_off,
    input logic                           send_ok,
    input logic [fc_cnt_w(BUF_DEPTH)-1:0] credit_cnt
);

    localparam int            CW    = fc_cnt_w(BUF_DEPTH);
    localparam logic [CW-1:0] FULL  = CW'(BUF_DEPTH);
    localparam logic          IS_CR = (MODE == FC_CREDIT);

    logic sent;
    always_comb sent = send_req & send_ok;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        credit_cnt <= FULL);                                              // R6

    AST_OK_TRACKS_CNT: assert property (@(posedge clk) disable iff (rst)
        IS_CR |-> (send_ok == (credit_cnt != '0)));                       // R2

    AST_SEND_TAKES: assert property (@(posedge clk) disable iff (rst)
        (IS_CR && sent && !credit_ret) |=> credit_cnt == $past(credit_cnt) - 1'b1); // R3

    AST_RET_GIVES: assert property (@(posedge clk) disable iff (rst)
        (IS_CR && credit_ret && !sent && credit_cnt != FULL)
            |=> credit_cnt == $past(credit_cnt) + 1'b1);                  // R4

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (IS_CR && credit_ret && sent && credit_cnt != FULL) |=> $stable(credit_cnt)); // R5

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (IS_CR && credit_cnt == '0 && !credit_ret) |=> credit_cnt == '0); // R7

    AST_ONOFF_GATE: assert property (@(posedge clk) disable iff (rst)
        !IS_CR |-> (send_ok == !link_off && credit_cnt == '0));           // R8

endmodule

bind link_credit_ctrl link_credit_ctrl_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .MODE      (MODE)
) u_chk (.*);

// File: tb/tb_link_credit_ctrl.sv
module tb_link_credit_ctrl;
    import fc_pkg::*;

    localparam int DEPTH = 4;
    localparam int CW    = fc_cnt_w(DEPTH);
    localparam int NVEC  = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          send_req, credit_ret, link_off;
    logic          send_ok, oo_ok;
    logic [CW-1:0] credit_cnt, oo_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    link_credit_ctrl #(.BUF_DEPTH(DEPTH), .MODE(FC_CREDIT)) dut (
        .clk(clk), .rst(rst), .send_req(send_req), .credit_ret(credit_ret),
        .link_off(link_off), .send_ok(send_ok), .credit_cnt(credit_cnt));

    link_credit_ctrl #(.BUF_DEPTH(DEPTH), .MODE(FC_ONOFF)) dut_onoff (
        .clk(clk), .rst(rst), .send_req(send_req), .credit_ret(credit_ret),
        .link_off(link_off), .send_ok(oo_ok), .credit_cnt(oo_cnt));

    // {send_req, credit_ret, link_off, expected send_ok, expected count after edge}
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd3},  // R3 send from full
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd2},  // R3
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd1},  // R3
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd0},  // R3 last credit used
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd0},  // R7 R2 blocked at zero
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd1},  // R4 credit back
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd1},  // R5 send and credit together
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd2},  // R4
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd3},  // R4
        {1'b1, 1'b0, 1'b1, 1'b1, 3'd2},  // R9 off level ignored
        {1'b0, 1'b1, 1'b1, 1'b1, 3'd3},  // R9 R4
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd4},  // R4 back to full
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd4},  // R6 extra credit dropped
        {1'b1, 1'b1, 1'b0, 1'b1, 3'd3},  // R6 credit at full dropped, send counts
        {1'b0, 1'b0, 1'b0, 1'b1, 3'd3}   // R2 idle holds
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; send_req = 1'b0; credit_ret = 1'b0; link_off = 1'b0;
        step(); step();
        rst = 1'b0;
        #1;
        chk("R1 reset count", int'(credit_cnt), DEPTH);
        chk("R2 ok after reset", int'(send_ok), 1);

        for (int i = 0; i < NVEC; i++) begin
            send_req   = VEC[i][6];
            credit_ret = VEC[i][5];
            link_off   = VEC[i][4];
            #1;
            chk($sformatf("R2/R9 send_ok vec %0d", i), int'(send_ok), int'(VEC[i][3]));
            step();
            chk($sformatf("R3-R7 count vec %0d", i), int'(credit_cnt), int'(VEC[i][2:0]));
        end

        // Mid-run reset from a partly drained count
        send_req = 1'b1; credit_ret = 1'b0; link_off = 1'b0;
        step();
        chk("R3 drain before reset", int'(credit_cnt), 2);
        send_req = 1'b0; rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        chk("R1 mid-run reset", int'(credit_cnt), DEPTH);

        // On/off instance
        link_off = 1'b0; send_req = 1'b1;
        #1;
        chk("R8 on level lets send", int'(oo_ok), 1);
        link_off = 1'b1;
        #1;
        chk("R8 off level stops send", int'(oo_ok), 0);
        credit_ret = 1'b1;
        step();
        step();
        chk("R8 credits ignored", int'(oo_cnt), 0);
        chk("R8 still paused", int'(oo_ok), 0);
        credit_ret = 1'b0; link_off = 1'b0;
        #1;
        chk("R8 resume", int'(oo_ok), 1);
        send_req = 1'b0;
        step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule